// File: doc/BRIEF.md
# Timeslot Interchange Data Memory

This block is the storage half of a time-division switch. Each frame is split into 2^SLOT_W timeslots of one clock each. In every timeslot the word on the input bus is stored at the location named by a free-running slot counter, so one frame fills the whole memory in order. Independently, an external controller names on the address bus which stored word should leave in each timeslot. This reorders samples in time, and that reordering is the switching operation.

An active-low frame pulse realigns the slot counter to zero. A message-enable input bypasses the memory: the address word itself is sent to the output, which lets a controller inject constant patterns or messages. An output-enable input gates the output. It appears as a valid flag, and the data reads as zero whenever valid is low.

The input side has no handshake. A word is accepted in every timeslot. The output side carries only a valid flag and has no ready: the switch is a fixed-rate stream, so a downstream stage cannot apply back-pressure and must take every valid word in the cycle it appears.

Top module: `tsi_data_memory`

## Requirements
- R1: The slot counter starts at 0 after reset and advances by one every clock, wrapping from 2^SLOT_W-1 to 0. The word on `din` during the slot in which the counter holds s is stored at location s.
- R2: When `frame_n` is low at a rising edge, the next timeslot is slot 0, whatever the counter held before.
- R3: An address presented on `addr` in slot t is captured at that slot's rising edge. The selected word is on `dout` from the rising edge of slot t+1 onward, which is a read latency of exactly one timeslot.
- R4: A word written in input slot i is returned in output slot o = t+1 of the same frame when o is at least i+2. For o equal to i or i+1, the word written in slot i of the previous frame is returned.
- R5: When a read and a write target the same location at the same edge, the read returns the contents from before the write.
- R6: When `msg_en` is high in slot t, the full WORD_W-bit address word captured in slot t is driven on `dout` in slot t+1 in place of memory contents. `msg_en` low in slot t selects memory contents for slot t+1.
- R7: Only `addr[SLOT_W-1:0]` selects a memory location. The upper address bits have no effect on a memory read.
- R8: `out_en` sampled in slot t sets `dout_valid` in slot t+1. While `dout_valid` is low, `dout` is all zeros.
- R9: During reset and through the first timeslot after reset, `dout` is zero and `dout_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timeslot clock, one word per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame pulse, sampled on rising edge |
| din | input | WORD_W | Sample written in the current timeslot |
| addr | input | WORD_W | Read address, or message word when `msg_en` is high |
| msg_en | input | 1 | Selects address-word pass-through for the next slot |
| out_en | input | 1 | Enables the output for the next slot |
| dout | output | WORD_W | Output sample, zero when not valid |
| dout_valid | output | 1 | High when `dout` carries a driven word |

## Verification
The bench builds the block with SLOT_W = 4 and BANKS = 4. A whole frame is then sixteen cycles, so counter wrap, the previous-frame versus same-frame boundary, and frame pulses at arbitrary points all occur many times in a short run. Four banks exercise the banked memory variant: consecutive slots land in different banks, and collisions are tested across bank-select paths. Upper address bits above bit 3 are exercised for both aliasing and message pass-through.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // Source of the word placed on the output in a timeslot
  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_MSG = 1'b1
  } out_src_e;

  function automatic int unsigned bank_bits(input int unsigned banks);
    return (banks > 1) ? $clog2(banks) : 0;
  endfunction

endpackage

// File: rtl/tsi_slot_counter.sv
module tsi_slot_counter #(
  parameter int unsigned SLOT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  output logic [SLOT_W-1:0] slot
);

  localparam logic [SLOT_W-1:0] STEP = SLOT_W'(1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (!frame_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + STEP;
    end
  end

  assign slot = slot_q;

  // R2: a frame pulse forces slot zero next
  p_frame_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (slot == '0));

  // R1: without a pulse the counter steps by one, wrapping
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> (slot == $past(slot) + STEP));

endmodule

// File: rtl/tsi_word_store.sv
module tsi_word_store #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 11,
  parameter int unsigned BANKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned LB    = tsi_pkg::bank_bits(BANKS);
  localparam int unsigned ROW_W = SLOT_W - LB;
  localparam int unsigned ROWS  = 1 << ROW_W;

  generate
    if (BANKS <= 1) begin : g_flat
      logic [WORD_W-1:0] mem [ROWS];
      logic [WORD_W-1:0] rd_q;

      // Read uses the pre-write contents (read before write)
      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rd_q <= mem[raddr];
      end

      assign rdata = rd_q;
    end else begin : g_banked
      logic [WORD_W-1:0] bank_rd [BANKS];
      logic [LB-1:0]     sel_q;

      for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] mem [ROWS];
        logic [WORD_W-1:0] rd_q;
        logic              hit;

        assign hit = we && (waddr[LB-1:0] == LB'(b));

        always_ff @(posedge clk) begin
          if (hit) mem[waddr[SLOT_W-1:LB]] <= wdata;
          rd_q <= mem[raddr[SLOT_W-1:LB]];
        end

        assign bank_rd[b] = rd_q;
      end

      always_ff @(posedge clk) begin
        sel_q <= raddr[LB-1:0];
      end

      assign rdata = bank_rd[sel_q];
    end
  endgenerate

  // R1: a location written at one edge reads back at the next
  p_write_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we ##1 (raddr == $past(waddr))) |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tsi_pkg::out_src_e src_in,
  input  logic              en_in,
  input  logic [WORD_W-1:0] msg_word,
  input  logic [WORD_W-1:0] mem_word,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);

  tsi_pkg::out_src_e src_q;
  logic              en_q;
  logic [WORD_W-1:0] msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= tsi_pkg::SRC_MEM;
      en_q  <= 1'b0;
      msg_q <= '0;
    end else begin
      src_q <= src_in;
      en_q  <= en_in;
      msg_q <= msg_word;
    end
  end

  always_comb begin
    dout = '0;
    if (en_q) begin
      dout = (src_q == tsi_pkg::SRC_MSG) ? msg_q : mem_word;
    end
  end

  assign dout_valid = en_q;

  // R8: a disabled output carries zeros
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0));

endmodule

// File: rtl/tsi_data_memory.sv
module tsi_data_memory #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 11,
  parameter int unsigned BANKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] addr,
  input  logic              msg_en,
  input  logic              out_en,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);

  initial begin
    assert (SLOT_W <= WORD_W) else $error("SLOT_W wider than the address word");
  end

  logic [SLOT_W-1:0] slot;

  // Input capture: the word of slot s is written one edge later at s
  logic [WORD_W-1:0] din_q;
  logic [SLOT_W-1:0] wa_q;
  logic              wv_q;

  // Read-side capture for the following timeslot
  logic [WORD_W-1:0] addr_q;
  logic              msg_q;
  logic              oe_q;

  logic [WORD_W-1:0] mem_word;
  tsi_pkg::out_src_e src_sel;

  tsi_slot_counter #(.SLOT_W(SLOT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .frame_n(frame_n),
    .slot   (slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= '0;
      wa_q   <= '0;
      wv_q   <= 1'b0;
      addr_q <= '0;
      msg_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      din_q  <= din;
      wa_q   <= slot;
      wv_q   <= 1'b1;
      addr_q <= addr;
      msg_q  <= msg_en;
      oe_q   <= out_en;
    end
  end

  tsi_word_store #(
    .WORD_W(WORD_W),
    .SLOT_W(SLOT_W),
    .BANKS (BANKS)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wv_q),
    .waddr(wa_q),
    .wdata(din_q),
    .raddr(addr_q[SLOT_W-1:0]),
    .rdata(mem_word)
  );

  assign src_sel = msg_q ? tsi_pkg::SRC_MSG : tsi_pkg::SRC_MEM;

  tsi_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_sel),
    .en_in     (oe_q),
    .msg_word  (addr_q),
    .mem_word  (mem_word),
    .dout      (dout),
    .dout_valid(dout_valid)
  );

  // Edges since reset, saturating; bounds the $past windows below
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R9: nothing is valid before two edges have passed since reset
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q < 2'd2) |-> (!dout_valid && dout == '0));

  // R8: valid follows out_en one timeslot after it is sampled
  p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (dout_valid == $past(out_en, 2)));

  // R6: message mode sends the captured address word unchanged
  p_msg_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(msg_en, 2) && $past(out_en, 2))
      |-> (dout == $past(addr, 2)));

endmodule

// File: tb/tsi_data_memory_test.sv
module tsi_data_memory_test;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned BANKS  = 4;
  localparam int unsigned SLOTS  = 1 << SLOT_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_n = 1'b1;
  logic [WORD_W-1:0] din = '0;
  logic [WORD_W-1:0] addr = '0;
  logic              msg_en = 1'b0;
  logic              out_en = 1'b0;
  logic [WORD_W-1:0] dout;
  logic              dout_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsi_data_memory #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .BANKS(BANKS)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .din(din), .addr(addr),
    .msg_en(msg_en), .out_en(out_en), .dout(dout), .dout_valid(dout_valid)
  );

  typedef struct {
    logic [WORD_W-1:0] d;
    logic              v;
    string             tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state built from the requirements
  logic [WORD_W-1:0] ref_mem [SLOTS];
  int unsigned       m_ts = 0;
  bit                m_wv = 0;
  int unsigned       m_wa = 0;
  logic [WORD_W-1:0] m_wd = '0;
  logic [WORD_W-1:0] m_addr = '0;
  bit                m_me = 0;
  bit                m_oe = 0;

  task automatic push_exp(input logic [WORD_W-1:0] d, input logic v, input string tag);
    exp_t e;
    e.d = d; e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: one timeslot, called at a falling edge, returns at the next one
  task automatic drive_slot(input logic [WORD_W-1:0] d_i, input logic [WORD_W-1:0] a_i,
                            input bit me_i, input bit oe_i, input bit fr_i,
                            input string tag);
    logic [WORD_W-1:0] ed;
    din = d_i; addr = a_i; msg_en = me_i; out_en = oe_i; frame_n = fr_i;
    @(posedge clk);
    // R3/R6/R8: result of this edge comes from the previous slot's capture
    ed = '0;
    if (m_oe) ed = m_me ? m_addr : ref_mem[m_addr[SLOT_W-1:0]];   // R7 low bits only
    push_exp(ed, m_oe, tag);
    // R5: write lands after the read of the same edge
    if (m_wv) ref_mem[m_wa] = m_wd;
    m_wv = 1; m_wa = m_ts; m_wd = d_i;
    m_addr = a_i; m_me = me_i; m_oe = oe_i;
    m_ts = fr_i ? ((m_ts + 1) % SLOTS) : 0;   // R1 wrap, R2 clear
    @(negedge clk);
  endtask

  // Monitor: compare each result away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dout !== e.d || dout_valid !== e.v) begin
        errors++;
        $display("FAIL %s: dout=%h valid=%b expected dout=%h valid=%b",
                 e.tag, dout, dout_valid, e.d, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state before any edge
    #1;
    checks++;
    if (dout !== '0 || dout_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9: dout=%h valid=%b expected dout=0000 valid=0", dout, dout_valid);
    end
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      out_en = 1'b1; msg_en = 1'b1; addr = 16'hFFFF;
      @(posedge clk);
      push_exp('0, 1'b0, "R9");
      @(negedge clk);
    end
    rst_n = 1'b1;
    // R9: the first slot after release is still quiet even with out_en high
    drive_slot(16'h0, 16'hFFFF, 1, 1, 1, "R9");
    // R2: align the frame
    drive_slot(16'h0, 16'h0, 0, 0, 0, "R2");
    // R1: fill one frame sequentially, output disabled
    for (int s = 0; s < SLOTS; s++) drive_slot(16'h1000 + s, 16'h0, 0, 0, 1, "R1");
    // R3: scrambled reads of a full frame
    for (int s = 0; s < SLOTS; s++)
      drive_slot(16'h2000 + s, WORD_W'((s * 5 + 3) % SLOTS), 0, 1, 1, "R3");
    // R5: read the location written in the same slot (collision)
    for (int s = 0; s < SLOTS; s++)
      drive_slot(16'h3000 + s, WORD_W'(m_ts), 0, 1, 1, "R5");
    // R4: read slot just behind and just ahead of the write slot
    for (int s = 0; s < SLOTS; s++)
      drive_slot(16'h4000 + s,
                 WORD_W'((s % 2 == 0) ? (m_ts + SLOTS - 1) % SLOTS : (m_ts + 1) % SLOTS),
                 0, 1, 1, "R4");
    // R4: every offset from the write slot across two frames
    for (int s = 0; s < 2 * SLOTS; s++)
      drive_slot(16'h5000 + s, WORD_W'((m_ts + SLOTS - (s % SLOTS)) % SLOTS), 0, 1, 1, "R4");
    // R6: message pass-through mixed with memory reads
    for (int s = 0; s < 2 * SLOTS; s++)
      drive_slot(16'h6000 + s, WORD_W'($urandom), bit'($urandom % 2), 1, 1, "R6");
    // R7: upper address bits must not change a memory read
    for (int s = 0; s < SLOTS; s++)
      drive_slot(16'h7000 + s, WORD_W'($urandom) | 16'hF000, 0, 1, 1, "R7");
    // R8: output enable toggling
    for (int s = 0; s < 2 * SLOTS; s++)
      drive_slot(16'h8000 + s, WORD_W'($urandom), bit'($urandom % 2),
                 bit'($urandom % 2), 1, "R8");
    // R2: frame pulses at arbitrary slots
    for (int s = 0; s < 4 * SLOTS; s++)
      drive_slot(16'h9000 + s, WORD_W'($urandom), 0, 1,
                 ($urandom % 7) != 0, "R2");
    drive_slot(16'h0, 16'h0, 0, 0, 1, "R8");
    drive_slot(16'h0, 16'h0, 0, 0, 1, "R8");
    finish_run();
  end

endmodule